// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block collects interrupt request lines and presents each processor of a small cluster with one 4-bit request level. Lines 1 to 15 are the primary sources, and the line number is also its priority: 15 is the highest. A rising edge on a line latches a bit in a pending register that all processors share. Software can also raise a line through a shared force register. Each processor has its own mask register, so the same pending state can be steered to different processors. Software removes pending bits through a write-one-to-clear register. A processor acknowledges the level it took, which retires that level.

An optional group of extended lines 16 to 31 shares one primary line, chosen by parameter (12 by default). That primary line is requested for a processor whenever one of the extended lines that this processor has unmasked is pending. When a processor acknowledges the primary level, the controller picks the highest-numbered unmasked pending extended line. It retires that line and records its number in the processor's identification register. The number always has bit 4 set, so any non-zero value marks an extended source.

Software reaches the registers through a plain word port: a single-cycle write strobe and a combinational read. There is no streaming data path, so there is no valid/ready handshake. Acknowledges are one-cycle strobes, and the level outputs are plain combinational status.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset the pending, force, mask and identification registers read zero and every processor's level output is 0.
- R2: A rising edge on line n (n in 1..31, with 16..31 only when extended lines are enabled) sets pending bit n at the next clock edge. A line held high does not set the bit again. Line 0 is ignored. The pending register reads at word address 0.
- R3: Writing a word to the clear register (address 2) clears pending bit n for every set bit n, and zero bits leave their pending bits untouched. A rising edge arriving in the same cycle as the clear keeps its pending bit set.
- R4: Writing a word to the force register (address 1) sets force bit n for every set bit n in 1..15, and the write clears no force bit. The force register reads back at address 1.
- R5: Each processor c has its own mask register at address 4+2c. Only its unmasked bits reach its level output, and writing one processor's mask does not change another processor's level.
- R6: A processor's level output is the highest n in 1..15 whose pending or force bit is set and whose mask bit is set, or 0 when there is none. It follows register changes without added delay.
- R7: An acknowledge strobe carrying level L clears force bit L if that bit is set, and otherwise clears pending bit L.
- R8: With extended lines enabled, the primary line (parameter, default 12) counts as requested for processor c whenever any pending extended bit is set in c's mask. This holds even when the primary line's own pending bit is clear.
- R9: An acknowledge at the primary level retires the highest pending extended line that the acknowledging processor has unmasked. It writes that line's number (16..31) into the processor's identification register at address 5+2c, or writes 0 if no such line is pending. The register changes at no other time.
- R10: The status register (address 3) reads the processor count minus one in bits 31:28, 0 in bit 27, the extended-line enable in bit 16 and the primary line number in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Interrupt request lines, bit n is line n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | 32 | Register read data, combinational |
| ack_valid | input | NCPU | Per-processor acknowledge strobe |
| ack_level | input | 4*NCPU | Per-processor acknowledged level, 4 bits each |
| cpu_level | output | 4*NCPU | Per-processor requested level, 4 bits each |

## Verification
Directed cases come first. One raises a line together with line 0, which shows that edges are latched and that line 0 is ignored. One clears with an all-zero word and then clears while a line is held high, which separates "clear had no effect" from "a held level re-latched". One lets an edge and a clear land in the same cycle. A forced bit and a pending bit are then acknowledged in turn, which shows which of the two an acknowledge retires. Two extended lines are split across two different processor masks, so the identification value shows that the choice follows the acknowledging processor's mask, and a final acknowledge with nothing left pending must read back 0. A seeded random phase then mixes line toggles, writes to every address and acknowledges, and compares each level output and a register read against a bench model after every cycle.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int NLINES  = 32;
  localparam int LVL_W   = 4;
  localparam int ID_W    = 5;
  localparam int BASE_W  = 16;

  typedef logic [NLINES-1:0] line_vec_t;
  typedef logic [LVL_W-1:0]  level_t;

  localparam line_vec_t LINES_ALL  = 32'hFFFF_FFFE;
  localparam line_vec_t LINES_BASE = 32'h0000_FFFE;

  localparam int ADR_PEND     = 0;
  localparam int ADR_FORCE    = 1;
  localparam int ADR_CLEAR    = 2;
  localparam int ADR_STATUS   = 3;
  localparam int ADR_CPU_BASE = 4;
endpackage

// File: rtl/imc_prio_enc.sv
module imc_prio_enc #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/imc_edge_capture.sv
module imc_edge_capture #(
  parameter int               W      = 32,
  parameter logic [W-1:0]     ENABLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines;
  end

  assign rise = lines & ~prev_q & ENABLE;
endmodule

// File: rtl/imc_cpu_port.sv
module imc_cpu_port
  import imc_pkg::*;
#(
  parameter bit EXT_EN   = 1'b1,
  parameter int EXT_LINE = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  line_vec_t           pend,
  input  logic [BASE_W-1:0]   frc,
  input  logic                mask_we,
  input  line_vec_t           wdata,
  input  logic                ack_valid,
  input  level_t              ack_level,
  output line_vec_t           mask,
  output level_t              level,
  output logic [ID_W-1:0]     id,
  output line_vec_t           clr_pend,
  output logic [BASE_W-1:0]   clr_frc
);
  localparam line_vec_t VALID   = EXT_EN ? LINES_ALL : LINES_BASE;
  localparam level_t    EXT_LVL = EXT_LINE[LVL_W-1:0];

  line_vec_t           mask_q;
  logic [BASE_W-1:0]   ext_hit;
  logic [BASE_W-1:0]   eff;
  logic [LVL_W-1:0]    ext_idx;
  logic                ext_any;
  logic                lvl_any;
  logic                ack_live;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata & VALID;
  end

  assign mask = mask_q;

  always_comb begin
    ext_hit = EXT_EN ? (pend[NLINES-1:BASE_W] & mask_q[NLINES-1:BASE_W]) : '0;
    eff     = pend[BASE_W-1:0] | frc;
    if (EXT_EN && (|ext_hit)) eff[EXT_LINE] = 1'b1;
    eff     = eff & mask_q[BASE_W-1:0];
    eff[0]  = 1'b0;
  end

  imc_prio_enc #(.W(BASE_W), .IW(LVL_W)) u_level_enc (
    .vec (eff),
    .idx (level),
    .any (lvl_any)
  );

  imc_prio_enc #(.W(BASE_W), .IW(LVL_W)) u_ext_enc (
    .vec (ext_hit),
    .idx (ext_idx),
    .any (ext_any)
  );

  assign ack_live = ack_valid && (ack_level != '0);

  always_comb begin
    clr_pend = '0;
    clr_frc  = '0;
    if (ack_live) begin
      if (frc[ack_level]) clr_frc[ack_level]  = 1'b1;
      else                clr_pend[ack_level] = 1'b1;
      if (EXT_EN && (ack_level == EXT_LVL) && ext_any)
        clr_pend[{1'b1, ext_idx}] = 1'b1;
    end
  end

  generate
    if (EXT_EN) begin : g_id
      logic [ID_W-1:0] id_q;
      always_ff @(posedge clk) begin
        if (!rst_n) id_q <= '0;
        else if (ack_live && (ack_level == EXT_LVL))
          id_q <= ext_any ? {1'b1, ext_idx} : '0;
      end
      assign id = id_q;

      a_r9_id_is_extended: assert property (@(posedge clk) disable iff (!rst_n)
        (id_q == '0) || id_q[ID_W-1]);

      a_r9_id_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_live && (ack_level == EXT_LVL)) |=> $stable(id_q));
    end else begin : g_no_id
      assign id = '0;
    end
  endgenerate

  a_r6_level_is_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> (mask_q[level] && lvl_any));
endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
  import imc_pkg::*;
#(
  parameter int NCPU     = 2,
  parameter bit EXT_EN   = 1'b1,
  parameter int EXT_LINE = 12,
  parameter int ADDR_W   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NLINES-1:0]      irq_lines,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [31:0]            wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [31:0]            rd_data,
  input  logic [NCPU-1:0]        ack_valid,
  input  logic [NCPU*LVL_W-1:0]  ack_level,
  output logic [NCPU*LVL_W-1:0]  cpu_level
);
  localparam line_vec_t VALID = EXT_EN ? LINES_ALL : LINES_BASE;
  localparam logic [31:0] STATUS_WORD =
    {4'(NCPU-1), 1'b0, 10'd0, EXT_EN, 12'd0, 4'(EXT_LINE)};

  line_vec_t           pend_q;
  logic [BASE_W-1:0]   frc_q;
  line_vec_t           rise;
  line_vec_t           clr_all;
  logic [BASE_W-1:0]   frc_clr_all;
  logic                clr_we;
  logic                frc_we;

  line_vec_t           mask_c     [NCPU];
  logic [ID_W-1:0]     id_c       [NCPU];
  line_vec_t           clr_pend_c [NCPU];
  logic [BASE_W-1:0]   clr_frc_c  [NCPU];

  assign clr_we = wr_en && (wr_addr == ADDR_W'(ADR_CLEAR));
  assign frc_we = wr_en && (wr_addr == ADDR_W'(ADR_FORCE));

  imc_edge_capture #(.W(NLINES), .ENABLE(VALID)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .lines (irq_lines),
    .rise  (rise)
  );

  generate
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      localparam int MASK_ADR = ADR_CPU_BASE + 2 * c;
      imc_cpu_port #(.EXT_EN(EXT_EN), .EXT_LINE(EXT_LINE)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend_q),
        .frc       (frc_q),
        .mask_we   (wr_en && (wr_addr == ADDR_W'(MASK_ADR))),
        .wdata     (wr_data),
        .ack_valid (ack_valid[c]),
        .ack_level (ack_level[c*LVL_W +: LVL_W]),
        .mask      (mask_c[c]),
        .level     (cpu_level[c*LVL_W +: LVL_W]),
        .id        (id_c[c]),
        .clr_pend  (clr_pend_c[c]),
        .clr_frc   (clr_frc_c[c])
      );
    end
  endgenerate

  always_comb begin
    clr_all     = clr_we ? wr_data : '0;
    frc_clr_all = '0;
    for (int c = 0; c < NCPU; c++) begin
      clr_all     = clr_all | clr_pend_c[c];
      frc_clr_all = frc_clr_all | clr_frc_c[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      frc_q  <= '0;
    end else begin
      pend_q <= ((pend_q & ~clr_all) | rise) & VALID;
      frc_q  <= ((frc_q & ~frc_clr_all) |
                 (frc_we ? wr_data[BASE_W-1:0] : '0)) & VALID[BASE_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADR_PEND))   rd_data = pend_q;
    if (rd_addr == ADDR_W'(ADR_FORCE))  rd_data = {16'd0, frc_q};
    if (rd_addr == ADDR_W'(ADR_STATUS)) rd_data = STATUS_WORD;
    for (int c = 0; c < NCPU; c++) begin
      if (rd_addr == ADDR_W'(ADR_CPU_BASE + 2 * c))     rd_data = mask_c[c];
      if (rd_addr == ADDR_W'(ADR_CPU_BASE + 2 * c + 1)) rd_data = {27'd0, id_c[c]};
    end
  end

  a_r2_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  a_r3_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend_q & $past(wr_data & ~rise)) == '0));

  a_r4_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
    frc_we |=> ((frc_q & $past(wr_data[BASE_W-1:0] & 16'hFFFE)) ==
                $past(wr_data[BASE_W-1:0] & 16'hFFFE)));
endmodule

// File: tb/mp_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mp_irq_ctrl_tb_top;
  localparam int NCPU = 2;
  localparam int EXTL = 12;
  localparam int AW   = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       irq_lines = '0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [AW-1:0]     rd_addr = '0;
  logic [31:0]       rd_data;
  logic [NCPU-1:0]   ack_valid = '0;
  logic [NCPU*4-1:0] ack_level = '0;
  logic [NCPU*4-1:0] cpu_level;

  always #2.5 clk = ~clk;

  mp_irq_ctrl #(.NCPU(NCPU), .EXT_EN(1'b1), .EXT_LINE(EXTL), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ack_valid(ack_valid), .ack_level(ack_level), .cpu_level(cpu_level)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench stimulus for the next cycle
  logic [31:0] s_irq = '0;
  logic        s_we = 1'b0;
  logic [AW-1:0] s_wa = '0;
  logic [31:0] s_wd = '0;
  logic [NCPU-1:0] s_av = '0;
  logic [3:0]  s_al [NCPU];

  // bench model
  logic [31:0] m_prev = '0;
  logic [31:0] m_pend = '0;
  logic [15:0] m_frc = '0;
  logic [31:0] m_mask [NCPU];
  logic [4:0]  m_id [NCPU];

  function automatic int hi_bit(logic [15:0] v);
    int r = 0;
    for (int i = 1; i < 16; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic int exp_level(int c);
    logic [15:0] e;
    e = m_pend[15:0] | m_frc;
    if (|(m_pend[31:16] & m_mask[c][31:16])) e[EXTL] = 1'b1;
    e = e & m_mask[c][15:0];
    e[0] = 1'b0;
    return hi_bit(e);
  endfunction

  function automatic logic [31:0] exp_read(int a);
    if (a == 0) return m_pend;
    if (a == 1) return {16'd0, m_frc};
    if (a == 3) return 32'h1001_000C;
    if (a >= 4 && a < 4 + 2 * NCPU) begin
      if (a % 2 == 0) return m_mask[(a - 4) / 2];
      return {27'd0, m_id[(a - 4) / 2]};
    end
    return 32'd0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] rise, cp, nmask [NCPU];
    logic [15:0] cf;
    logic [4:0]  nid [NCPU];
    rise = s_irq & ~m_prev & 32'hFFFF_FFFE;
    cp = (s_we && s_wa == 2) ? s_wd : '0;
    cf = '0;
    for (int c = 0; c < NCPU; c++) begin
      nmask[c] = (s_we && s_wa == AW'(4 + 2 * c)) ? (s_wd & 32'hFFFF_FFFE) : m_mask[c];
      nid[c] = m_id[c];
      if (s_av[c] && s_al[c] != 0) begin
        logic [15:0] hit;
        if (m_frc[s_al[c]]) cf[s_al[c]] = 1'b1;
        else                cp[s_al[c]] = 1'b1;
        if (s_al[c] == EXTL) begin
          hit = m_pend[31:16] & m_mask[c][31:16];
          nid[c] = 5'd0;
          for (int i = 0; i < 16; i++) if (hit[i]) nid[c] = 5'(16 + i);
          if (hit != 0) cp[nid[c]] = 1'b1;
        end
      end
    end
    m_pend = ((m_pend & ~cp) | rise) & 32'hFFFF_FFFE;
    m_frc  = ((m_frc & ~cf) | ((s_we && s_wa == 1) ? s_wd[15:0] : 16'd0)) & 16'hFFFE;
    m_prev = s_irq;
    for (int c = 0; c < NCPU; c++) begin
      m_mask[c] = nmask[c];
      m_id[c] = nid[c];
    end
  endtask

  // one clock: drive at negedge, update model at posedge, check levels after
  task automatic cycle();
    @(negedge clk);
    irq_lines = s_irq; wr_en = s_we; wr_addr = s_wa; wr_data = s_wd;
    ack_valid = s_av;
    for (int c = 0; c < NCPU; c++) ack_level[c*4 +: 4] = s_al[c];
    @(posedge clk);
    #1;
    model_step();
    for (int c = 0; c < NCPU; c++)
      check("R6 level", 32'(cpu_level[c*4 +: 4]), 32'(exp_level(c)));
    s_we = 1'b0; s_av = '0;
  endtask

  task automatic rd_chk(int a, string tag);
    rd_addr = AW'(a);
    #0.2;
    check(tag, rd_data, exp_read(a));
  endtask

  task automatic wr(int a, logic [31:0] d);
    s_we = 1'b1; s_wa = AW'(a); s_wd = d;
    cycle();
  endtask

  task automatic ack(int c, int l);
    s_av = '0; s_av[c] = 1'b1; s_al[c] = 4'(l);
    cycle();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCPU; c++) begin m_mask[c] = '0; m_id[c] = '0; s_al[c] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    for (int c = 0; c < NCPU; c++) check("R1 level", 32'(cpu_level[c*4 +: 4]), 32'd0);
    for (int a = 0; a < 8; a++) if (a != 3) rd_chk(a, "R1 reset reg");
    rd_chk(3, "R10 status");
    check("R10 status literal", rd_data, 32'h1001_000C);

    // R5 masks per processor
    wr(4, 32'hFFFF_FFFE);
    wr(6, 32'h0000_0F00);
    rd_chk(4, "R5 mask0"); rd_chk(6, "R5 mask1");
    // R2 line 5 plus line 0
    s_irq = 32'h0000_0021; cycle();
    rd_chk(0, "R2 edge, line 0 ignored");
    check("R2 pend literal", rd_data, 32'h0000_0020);
    check("R5 cpu1 masked", 32'(cpu_level[7:4]), 32'd0);
    // R3 zero clear, then clear while held high
    wr(2, 32'h0); rd_chk(0, "R3 zero clear no effect");
    wr(2, 32'h20); rd_chk(0, "R3 clear with held line");
    check("R3 pend cleared", rd_data, 32'h0);
    s_irq = 32'h0; cycle();
    // R3 edge in same cycle as clear
    s_irq = 32'h0000_0200; wr(2, 32'h200);
    rd_chk(0, "R3 edge beats clear");
    check("R5 cpu1 sees 9", 32'(cpu_level[7:4]), 32'd9);
    // R4 force
    wr(1, 32'h0000_0800); rd_chk(1, "R4 force readback");
    check("R4 forced level", 32'(cpu_level[3:0]), 32'd11);
    // R7 acknowledges
    ack(0, 11); rd_chk(1, "R7 force retired"); rd_chk(0, "R7 pending kept");
    ack(1, 9);  rd_chk(0, "R7 pending retired");
    s_irq = 32'h0; cycle();
    // R8 extended lines
    wr(6, 32'h0002_1000);
    s_irq = 32'h0012_0000; cycle();
    rd_chk(0, "R8 extended pending");
    check("R8 primary cpu0", 32'(cpu_level[3:0]), 32'd12);
    check("R8 primary cpu1", 32'(cpu_level[7:4]), 32'd12);
    // R9 acknowledge ids
    ack(0, 12); rd_chk(5, "R9 id cpu0");
    check("R9 id literal", rd_data, 32'd20);
    ack(1, 12); rd_chk(7, "R9 id cpu1");
    check("R9 id1 literal", rd_data, 32'd17);
    ack(0, 12); rd_chk(5, "R9 id none pending");
    check("R9 id zero", rd_data, 32'd0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 2 == 0) s_irq[$urandom % 32] ^= 1'b1;
      if ($urandom % 4 == 0) begin
        s_we = 1'b1; s_wa = AW'($urandom % 8); s_wd = $urandom;
      end
      for (int c = 0; c < NCPU; c++) begin
        if ($urandom % 3 == 0) begin
          s_av[c] = 1'b1;
          s_al[c] = ($urandom % 5 == 0) ? 4'($urandom) : cpu_level[c*4 +: 4];
        end
      end
      cycle();
      rd_chk(int'($urandom % 8), "R2 R4 R5 R9 random readback");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule